// File: doc/BRIEF.md
# Serial DAC Word Transmitter

This block takes signed 16-bit audio samples from a valid/ready handshake and sends each one to an external serial converter over three wires. The wires are a bit clock, a serial data line and an active-low latch strobe. The bit clock is made from the faster system clock. Parameters give the number of system-clock cycles for the clock high phase, the clock low phase, the data setup time, the strobe width and the quiet gap around the strobe. This lets the port meet the converter's minimum pulse widths and setup/hold margins at any system clock rate. Each word goes out most significant bit first, and the converter samples data on the rising bit-clock edge. After the sixteenth rising edge, one low pulse on the strobe moves the word into the converter's parallel register.

The default counts are sized for a 100 MHz system clock:

| Quantity | Cycles | Time |
|---|---|---|
| Clock high | 4 | 40 ns |
| Clock low | 6 | 60 ns |
| Bit period | 10 | 100 ns |
| Setup | 2 | 20 ns |
| Strobe low | 5 | 50 ns |
| Each gap | 5 | 50 ns |

A sample is accepted only in the idle state, so a new word never overlaps the strobe of the previous one.

**States**

| State | What happens |
|---|---|
| `ST_IDLE` | Ready is high. |
| `ST_CLK_LO` | Low phase of the bit clock; the data bit is presented. |
| `ST_CLK_HI` | High phase of the bit clock. |
| `ST_PRE_LATCH` | Gap between the last falling clock edge and the strobe. |
| `ST_LATCH` | The strobe is low. |
| `ST_POST_LATCH` | Gap after the strobe before ready returns. |

**Transitions**

| Transition | Condition |
|---|---|
| `ST_IDLE` to `ST_CLK_LO` | A sample is accepted. |
| `ST_CLK_LO` to `ST_CLK_HI` | The low-phase timer expires. |
| `ST_CLK_HI` to `ST_CLK_LO` | The high-phase timer expires and bits remain. |
| `ST_CLK_HI` to `ST_PRE_LATCH` | The high-phase timer expires after the final bit. |
| `ST_PRE_LATCH` to `ST_LATCH` | The pre-strobe gap expires. |
| `ST_LATCH` to `ST_POST_LATCH` | The strobe timer expires. |
| `ST_POST_LATCH` to `ST_IDLE` | The post-strobe gap expires. |

Top module: `dac_word_tx`

## Requirements
- R1: Ready is high only in the idle state. A sample is taken on a clock edge where valid and ready are both high. Valid and the sample bus are ignored while a word is in flight.
- R2: The 16 bits shifted out between two strobes equal the accepted sample, most significant bit (bit 15) first.
- R3: Every high phase of the bit clock lasts exactly HI_CYC system cycles (default 4).
- R4: Inside a word, every low phase of the bit clock between two high phases lasts exactly max(LO_CYC, SETUP_CYC) cycles (default 6). The bit period is therefore at least 10 cycles.
- R5: The data line changes only on a falling bit-clock edge or while idle. It is held for the whole high phase and has been stable for at least SETUP_CYC cycles when the clock rises.
- R6: Exactly 16 rising bit-clock edges occur before each strobe, and the bit clock is low whenever the strobe is low.
- R7: The strobe falls GAP_CYC cycles after the last falling clock edge and stays low for exactly LE_CYC cycles. Ready returns GAP_CYC cycles after the strobe rises.
- R8: The strobe falls exactly 16*(max(LO_CYC,SETUP_CYC)+HI_CYC)+GAP_CYC cycles after the accepting edge.
- R9: Out of reset and when idle, the bit clock is low, the strobe is high and ready is high.
- R10: A synchronous active-high reset aborts a transfer in progress. The cycle after reset shows idle levels, and the next sample is sent correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid_i | input | 1 | Sample offered |
| smp_data_i | input | 16 | Signed sample, two's complement |
| smp_ready_o | output | 1 | Block can take a sample |
| dac_bclk_o | output | 1 | Bit clock to the converter |
| dac_sdata_o | output | 1 | Serial data, sampled on the rising bit clock |
| dac_latch_n_o | output | 1 | Active-low word latch strobe |

## Verification
The assertions assume that valid is driven synchronously and is never unknown after reset. They also assume that reset is held for at least one full system clock, because the idle-level and width counters restart from reset.

The bench drives every input half a cycle away from the sampling edge. While a word is in flight, it holds valid high with a corrupted sample, so that the ignored-input rule is exercised without ever presenting an ambiguous handshake. Reset is raised in the middle of a word to test the abort path.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_CLK_LO     = 3'd1,
        ST_CLK_HI     = 3'd2,
        ST_PRE_LATCH  = 3'd3,
        ST_LATCH      = 3'd4,
        ST_POST_LATCH = 3'd5
    } tx_state_e;

    function automatic int unsigned max_cyc(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dac_tx_phase_timer.sv
module dac_tx_phase_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/dac_tx_shifter.sv
module dac_tx_shifter #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              shift_i,
    output logic              msb_o,
    output logic              last_o
);

    localparam int unsigned IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

    logic [WORD_W-1:0] sreg_q;
    logic [IDX_W-1:0]  idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q <= '0;
            idx_q  <= '0;
        end else if (load_i) begin
            sreg_q <= word_i;
            idx_q  <= '0;
        end else if (shift_i) begin
            sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
            idx_q  <= idx_q + 1'b1;
        end
    end

    assign msb_o  = sreg_q[WORD_W-1];
    assign last_o = (idx_q == LAST_IDX);

endmodule

// File: rtl/dac_word_tx.sv
module dac_word_tx
    import dac_tx_pkg::*;
#(
    parameter int unsigned WORD_W    = 16,
    parameter int unsigned HI_CYC    = 4,
    parameter int unsigned LO_CYC    = 6,
    parameter int unsigned SETUP_CYC = 2,
    parameter int unsigned LE_CYC    = 5,
    parameter int unsigned GAP_CYC   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid_i,
    input  logic [WORD_W-1:0] smp_data_i,
    output logic              smp_ready_o,
    output logic              dac_bclk_o,
    output logic              dac_sdata_o,
    output logic              dac_latch_n_o
);

    localparam int unsigned LOW_LEN  = max_cyc(LO_CYC, SETUP_CYC);
    localparam int unsigned MAX_LEN  = max_cyc(max_cyc(LOW_LEN, HI_CYC), max_cyc(LE_CYC, GAP_CYC));
    localparam int unsigned CNT_W    = $clog2(MAX_LEN + 1);
    localparam logic [CNT_W-1:0] LD_LOW  = CNT_W'(LOW_LEN - 1);
    localparam logic [CNT_W-1:0] LD_HIGH = CNT_W'(HI_CYC - 1);
    localparam logic [CNT_W-1:0] LD_LE   = CNT_W'(LE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_GAP  = CNT_W'(GAP_CYC - 1);

    tx_state_e        state_q, state_d;
    logic             tmr_zero, tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             sh_last, sh_load, sh_shift;
    logic             bclk_q, latch_n_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (smp_valid_i) state_d = ST_CLK_LO;
            ST_CLK_LO:     if (tmr_zero) state_d = ST_CLK_HI;
            ST_CLK_HI:     if (tmr_zero) state_d = sh_last ? ST_PRE_LATCH : ST_CLK_LO;
            ST_PRE_LATCH:  if (tmr_zero) state_d = ST_LATCH;
            ST_LATCH:      if (tmr_zero) state_d = ST_POST_LATCH;
            ST_POST_LATCH: if (tmr_zero) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // timer reload on every state change
    always_comb begin
        tmr_load = (state_d != state_q);
        tmr_val  = '0;
        unique case (state_d)
            ST_CLK_LO:     tmr_val = LD_LOW;
            ST_CLK_HI:     tmr_val = LD_HIGH;
            ST_LATCH:      tmr_val = LD_LE;
            ST_PRE_LATCH,
            ST_POST_LATCH: tmr_val = LD_GAP;
            default:       tmr_val = '0;
        endcase
    end

    assign sh_load  = (state_q == ST_IDLE)   && (state_d == ST_CLK_LO);
    assign sh_shift = (state_q == ST_CLK_HI) && (state_d == ST_CLK_LO);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q    <= 1'b0;
            latch_n_q <= 1'b1;
        end else begin
            bclk_q    <= (state_d == ST_CLK_HI);
            latch_n_q <= (state_d != ST_LATCH);
        end
    end

    dac_tx_phase_timer #(.CNT_W(CNT_W)) tmr_i (
        .clk        (clk),
        .rst        (rst),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    dac_tx_shifter #(.WORD_W(WORD_W)) shf_i (
        .clk     (clk),
        .rst     (rst),
        .load_i  (sh_load),
        .word_i  (smp_data_i),
        .shift_i (sh_shift),
        .msb_o   (dac_sdata_o),
        .last_o  (sh_last)
    );

    assign smp_ready_o   = (state_q == ST_IDLE);
    assign dac_bclk_o    = bclk_q;
    assign dac_latch_n_o = latch_n_q;

    // checking counters derived from the port waveforms
    logic [31:0] hi_run_q, le_run_q, rise_cnt_q;
    logic        bclk_d_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run_q   <= '0;
            le_run_q   <= '0;
            rise_cnt_q <= '0;
            bclk_d_q   <= 1'b0;
        end else begin
            bclk_d_q <= dac_bclk_o;
            hi_run_q <= dac_bclk_o ? hi_run_q + 1 : '0;
            le_run_q <= !dac_latch_n_o ? le_run_q + 1 : '0;
            if (!dac_latch_n_o)               rise_cnt_q <= '0;
            else if (dac_bclk_o && !bclk_d_q) rise_cnt_q <= rise_cnt_q + 1;
        end
    end

    assert_hi_width_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(dac_bclk_o) |-> hi_run_q == HI_CYC);

    assert_data_hold_R5: assert property (@(posedge clk) disable iff (rst)
        dac_bclk_o |-> $stable(dac_sdata_o));

    assert_latch_clk_low_R6: assert property (@(posedge clk) disable iff (rst)
        !dac_latch_n_o |-> !dac_bclk_o);

    assert_bits_per_word_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(dac_latch_n_o) |-> rise_cnt_q == WORD_W);

    assert_strobe_width_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(dac_latch_n_o) |-> le_run_q == LE_CYC);

    assert_ready_idle_R1: assert property (@(posedge clk) disable iff (rst)
        smp_ready_o |-> (!dac_bclk_o && dac_latch_n_o));

endmodule

// File: tb/dac_word_tx_tb.sv
module dac_word_tx_tb_top;

    localparam int W     = 16;
    localparam int HI    = 4;
    localparam int LO    = 6;
    localparam int SETUP = 2;
    localparam int LE    = 5;
    localparam int GAP   = 5;
    localparam int LOWL  = (LO > SETUP) ? LO : SETUP;
    localparam int LAT   = W * (LOWL + HI) + GAP;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_valid = 1'b0;
    logic [W-1:0] smp_data = '0;
    logic ready, bclk, sdata, latch_n;

    int n_tests = 0;
    int n_fail  = 0;
    longint cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dac_word_tx #(.WORD_W(W), .HI_CYC(HI), .LO_CYC(LO), .SETUP_CYC(SETUP),
                  .LE_CYC(LE), .GAP_CYC(GAP)) dut_i (
        .clk(clk), .rst(rst), .smp_valid_i(smp_valid), .smp_data_i(smp_data),
        .smp_ready_o(ready), .dac_bclk_o(bclk), .dac_sdata_o(sdata),
        .dac_latch_n_o(latch_n));

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected word queue
    logic [W-1:0] exp_q [0:63];
    int wr_i = 0;
    int rd_i = 0;
    longint acc_cyc = 0;

    // waveform monitor
    logic pb = 1'b0, ple = 1'b1, pd = 1'b0, prdy = 1'b1;
    int hi_run = 0, lo_run = 0, stab = 0, le_run = 0;
    int since_fall = 0, since_rise_le = 0, nbits = 0;
    bit le_done = 1'b0;
    logic [W-1:0] cap = '0;

    always @(negedge clk) begin
        if (rst) begin
            pb = 1'b0; ple = 1'b1; pd = sdata; prdy = ready;
            hi_run = 0; lo_run = 0; stab = 0; le_run = 0;
            since_fall = 0; since_rise_le = 0; nbits = 0; le_done = 1'b0; cap = '0;
        end else begin
            if (bclk && !pb) begin
                chk(stab >= SETUP, "R5 setup", stab, SETUP);
                if (nbits > 0) chk(lo_run == LOWL, "R4 low phase", lo_run, LOWL);
                chk(!ready, "R1 ready low while busy", ready, 0);
                chk(latch_n, "R6 strobe high at clock rise", latch_n, 1);
                cap = {cap[W-2:0], sdata};
                nbits++;
            end
            if (!bclk && pb) begin
                chk(hi_run == HI, "R3 high phase", hi_run, HI);
                since_fall = 0;
            end
            if (bclk && pb && sdata !== pd)
                chk(1'b0, "R5 data changed while clock high", sdata, pd);
            if (!latch_n && ple) begin
                chk(nbits == W, "R6 bit count", nbits, W);
                chk(cap == exp_q[rd_i], "R2 latched word", cap, exp_q[rd_i]);
                chk(since_fall == GAP, "R7 pre-strobe gap", since_fall, GAP);
                chk(cyc - acc_cyc == LAT, "R8 latency", cyc - acc_cyc, LAT);
                rd_i++;
                nbits = 0;
            end
            if (latch_n && !ple) begin
                chk(le_run == LE, "R7 strobe width", le_run, LE);
                since_rise_le = 0;
                le_done = 1'b1;
            end
            if (ready && !prdy && le_done) begin
                chk(since_rise_le == GAP, "R7 post-strobe gap", since_rise_le, GAP);
                le_done = 1'b0;
            end
            hi_run = bclk ? hi_run + 1 : 0;
            lo_run = !bclk ? lo_run + 1 : 0;
            stab = (sdata === pd) ? stab + 1 : 1;
            le_run = !latch_n ? le_run + 1 : 0;
            since_fall++;
            since_rise_le++;
            pb = bclk; ple = latch_n; pd = sdata; prdy = ready;
        end
    end

    task automatic send(input logic [W-1:0] w);
        exp_q[wr_i] = w;
        wr_i++;
        smp_valid = 1'b1;
        smp_data  = w;
        while (!ready) @(negedge clk);
        @(negedge clk);
        acc_cyc = cyc;
        // keep valid high with garbage while busy: must be ignored (R1)
        smp_data = ~w;
        repeat (20) @(negedge clk);
        smp_valid = 1'b0;
        smp_data  = 16'hDEAD;
    endtask

    task automatic drain();
        while (!(ready && rd_i == wr_i)) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!bclk && latch_n, "R9 levels in reset", {bclk, latch_n}, 1);
        rst = 1'b0;
        @(negedge clk);
        chk(!bclk, "R9 idle clock low", bclk, 0);
        chk(latch_n, "R9 idle strobe high", latch_n, 1);
        chk(ready, "R9 idle ready", ready, 1);

        send(16'h0000); send(16'h7FFF); send(16'h8000);
        send(16'hFFFF); send(16'h0001); send(16'hA5C3);
        drain();
        for (int i = 0; i < W; i++) begin
            send(16'(1 << i));
            if (wr_i - rd_i > 8) drain();
        end
        drain();
        for (int k = 0; k < 8; k++) send(16'((k * 40503 + 12345) & 16'hFFFF));
        drain();
        chk(ready && !bclk && latch_n, "R9 idle after words", {ready, bclk, latch_n}, 5);

        // abort mid-word (R10)
        exp_q[wr_i] = 16'h1234; wr_i++;
        smp_valid = 1'b1; smp_data = 16'h1234;
        while (!ready) @(negedge clk);
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (60) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!bclk && latch_n && ready, "R10 idle after abort", {ready, bclk, latch_n}, 5);
        rst = 1'b0;
        rd_i = wr_i;
        @(negedge clk);
        send(16'h6C39);
        drain();
        chk(rd_i == wr_i, "R10 word after abort latched", rd_i, wr_i);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule